// File: doc/BRIEF.md
# Partial-Array Refresh Row Sequencer

This block produces the row addresses that a pseudo-static memory refreshes by itself. The array holds 4M words of 16 bits in rows of 256 words, so there are 16384 rows. A 3-bit selection code picks the part of the array that keeps its data. The part can be all of it, a half, a quarter or an eighth, placed at the low end or the high end of the address space. The code can also select nothing at all.

A refresh timer supplies a single-cycle tick. On each tick taken while the block is enabled, the sequencer sends out one request for its current row, then moves to the next row. After the last row of the selected window it goes back to the first. The window bounds currently in force are available as outputs, together with a flag that shows no refresh is needed. The selection code is applied on a tick. When it differs from the code in force, the row pointer restarts at the first row of the new window.

Top module: `par_refresh_seq`

## Requirements
- R1: After reset, refresh_req is 0, row_addr is 0, win_first is 0, win_last is 16383 and no_refresh is 0, which is the full-array selection.
- R2: Code 000, once applied, gives a window of rows 0 to 16383 (word addresses 000000h to 3FFFFFh, row = word address >> 8).
- R3: Codes 001, 010 and 011, once applied, give low-anchored windows starting at row 0 and ending at rows 8191, 4095 and 2047.
- R4: Codes 111, 110 and 101, once applied, give high-anchored windows ending at row 16383 and starting at rows 14336, 12288 and 8192.
- R5: Code 100, once applied, sets no_refresh to 1 and reports both bounds as 0. While it is in force, no request is issued.
- R6: A tick with en high under a code other than 100 raises refresh_req for exactly the next cycle, with row_addr holding the current row. The pointer then advances by one.
- R7: After a request for the window's last row, the next request is for the window's first row.
- R8: On a tick whose code differs from the code in force, the new code is applied and the request from that tick addresses the first row of the new window.
- R9: While en is low, a tick has no effect: no request is issued, neither the code nor the bounds change, and the row sequence resumes where it stopped.
- R10: Every request addresses a row between win_first and win_last inclusive. row_addr changes only together with a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_code | input | 3 | Partial-array selection code |
| tick | input | 1 | Refresh interval strobe, one cycle |
| en | input | 1 | Refresh enable |
| row_addr | output | 14 | Row to refresh, valid with refresh_req |
| refresh_req | output | 1 | One-cycle refresh request |
| win_first | output | 14 | First row of the window in force |
| win_last | output | 14 | Last row of the window in force |
| no_refresh | output | 1 | The code in force selects no rows |

## Verification
The hardest case to reach is the wrap at the end of each window, because it takes thousands of ticks. The stimulus drives an unbroken run of ticks through the 2048-row high and low eighth windows, and also through a quarter window. Code changes are made in the middle of a window, while en is low, and into and out of code 100. This exercises the reload path against a running pointer and against a pointer left at rest.

// File: rtl/par_refresh_pkg.sv
`timescale 1ns/1ps
package par_refresh_pkg;
  // selection code: [2] anchors at the high end, [1:0] is the halving count
  typedef struct packed {
    logic       high;
    logic [1:0] halvings;
  } par_code_t;

  localparam logic [2:0] CODE_FULL = 3'b000;
  localparam logic [2:0] CODE_NONE = 3'b100;

  function automatic logic code_is_none(input logic [2:0] c);
    return c == CODE_NONE;
  endfunction
endpackage

// File: rtl/par_window_decode.sv
`timescale 1ns/1ps
module par_window_decode import par_refresh_pkg::*; #(
  parameter int ROW_BITS = 14
) (
  input  logic [2:0]          code,
  output logic [ROW_BITS-1:0] first_row,
  output logic [ROW_BITS-1:0] last_row,
  output logic                none
);
  localparam logic [ROW_BITS-1:0] ALL_ONES = '1;

  par_code_t             c;
  logic [ROW_BITS-1:0]   span_mask;

  assign c = par_code_t'(code);

  always_comb begin
    span_mask = ALL_ONES >> c.halvings;
    none      = code_is_none(code);
    if (none) begin
      first_row = '0;
      last_row  = '0;
    end else if (c.high) begin
      first_row = ~span_mask;
      last_row  = ALL_ONES;
    end else begin
      first_row = '0;
      last_row  = span_mask;
    end
  end

  // every decoded window keeps first <= last
  always_comb begin
    a_r4_window_ordered: assert (first_row <= last_row);
  end
endmodule

// File: rtl/par_row_counter.sv
`timescale 1ns/1ps
module par_row_counter #(
  parameter int ROW_BITS = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                fire,
  input  logic                reload,
  input  logic                advance,
  input  logic [ROW_BITS-1:0] first_row,
  input  logic [ROW_BITS-1:0] last_row,
  output logic [ROW_BITS-1:0] start_row
);
  localparam logic [ROW_BITS-1:0] ONE = 1;

  logic [ROW_BITS-1:0] ptr;
  logic [ROW_BITS-1:0] next_ptr;

  always_comb begin
    start_row = reload ? first_row : ptr;
    if (!advance)
      next_ptr = start_row;
    else if (start_row == last_row)
      next_ptr = first_row;
    else
      next_ptr = start_row + ONE;
  end

  always_ff @(posedge clk) begin
    if (rst)
      ptr <= '0;
    else if (fire)
      ptr <= next_ptr;
  end

  a_r7_wrap_to_first: assert property (@(posedge clk) disable iff (rst)
    (fire && advance && start_row == last_row) |=> ptr == $past(first_row));

  a_r9_hold_without_fire: assert property (@(posedge clk) disable iff (rst)
    !fire |=> $stable(ptr));
endmodule

// File: rtl/par_refresh_seq.sv
`timescale 1ns/1ps
module par_refresh_seq import par_refresh_pkg::*; #(
  parameter int ROW_BITS = 14
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          sel_code,
  input  logic                tick,
  input  logic                en,
  output logic [ROW_BITS-1:0] row_addr,
  output logic                refresh_req,
  output logic [ROW_BITS-1:0] win_first,
  output logic [ROW_BITS-1:0] win_last,
  output logic                no_refresh
);
  localparam logic [ROW_BITS-1:0] ALL_ONES = '1;

  logic [2:0]          cur_code;
  logic                fire;
  logic                changed;
  logic [ROW_BITS-1:0] dec_first;
  logic [ROW_BITS-1:0] dec_last;
  logic                dec_none;
  logic [ROW_BITS-1:0] start_row;

  assign fire    = tick && en;
  assign changed = sel_code != cur_code;

  par_window_decode #(.ROW_BITS(ROW_BITS)) u_dec (
    .code      (sel_code),
    .first_row (dec_first),
    .last_row  (dec_last),
    .none      (dec_none)
  );

  par_row_counter #(.ROW_BITS(ROW_BITS)) u_cnt (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .reload    (changed),
    .advance   (!dec_none),
    .first_row (dec_first),
    .last_row  (dec_last),
    .start_row (start_row)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cur_code    <= CODE_FULL;
      refresh_req <= 1'b0;
      row_addr    <= '0;
      win_first   <= '0;
      win_last    <= ALL_ONES;
      no_refresh  <= 1'b0;
    end else begin
      refresh_req <= fire && !dec_none;
      if (fire) begin
        cur_code   <= sel_code;
        win_first  <= dec_first;
        win_last   <= dec_last;
        no_refresh <= dec_none;
        if (!dec_none)
          row_addr <= start_row;
      end
    end
  end

  a_r6_req_after_tick: assert property (@(posedge clk) disable iff (rst)
    (fire && !dec_none) |=> refresh_req);

  a_r9_no_req_without_tick: assert property (@(posedge clk) disable iff (rst)
    !fire |=> !refresh_req);

  a_r5_none_blocks_req: assert property (@(posedge clk) disable iff (rst)
    no_refresh |-> !refresh_req);

  a_r10_req_in_window: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> (row_addr >= win_first && row_addr <= win_last));

  a_r10_addr_stable_between: assert property (@(posedge clk) disable iff (rst)
    !refresh_req |-> $stable(row_addr));

  a_r8_reload_first_row: assert property (@(posedge clk) disable iff (rst)
    (fire && changed && !dec_none) |=> row_addr == $past(dec_first));
endmodule

// File: tb/sim_par_refresh_seq.sv
`timescale 1ns/1ps
module sim_par_refresh_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  sel = 3'b000;
  logic        tick = 1'b0;
  logic        en = 1'b0;
  logic [13:0] row_addr;
  logic        refresh_req;
  logic [13:0] win_first;
  logic [13:0] win_last;
  logic        no_refresh;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // reference state
  int m_code = 0;
  int m_row = 0;
  int m_addr = 0;
  int m_req = 0;
  int m_first = 0;
  int m_last = 16383;
  int m_none = 0;
  string m_tag = "R1";

  always #2 clk = ~clk;

  par_refresh_seq u0 (
    .clk(clk), .rst(rst), .sel_code(sel), .tick(tick), .en(en),
    .row_addr(row_addr), .refresh_req(refresh_req),
    .win_first(win_first), .win_last(win_last), .no_refresh(no_refresh)
  );

  function automatic void window(input int c, output int f, output int l);
    case (c)
      0: begin f = 0;     l = 16383; end
      1: begin f = 0;     l = 8191;  end
      2: begin f = 0;     l = 4095;  end
      3: begin f = 0;     l = 2047;  end
      4: begin f = 0;     l = 0;     end
      5: begin f = 8192;  l = 16383; end
      6: begin f = 12288; l = 16383; end
      default: begin f = 14336; l = 16383; end
    endcase
  endfunction

  function automatic string bound_tag(input int c);
    if (c == 0) return "R2";
    if (c == 4) return "R5";
    if (c < 4) return "R3";
    return "R4";
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp, input string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic compare();
    chk(int'(refresh_req) == m_req, m_tag, int'(refresh_req), m_req, "refresh_req");
    chk(int'(row_addr) == m_addr, m_tag, int'(row_addr), m_addr, "row_addr");
    chk(int'(win_first) == m_first, bound_tag(m_code), int'(win_first), m_first, "win_first");
    chk(int'(win_last) == m_last, bound_tag(m_code), int'(win_last), m_last, "win_last");
    chk(int'(no_refresh) == m_none, "R5", int'(no_refresh), m_none, "no_refresh");
    if (refresh_req) // R10 window containment
      chk(row_addr >= win_first && row_addr <= win_last, "R10", int'(row_addr), m_first, "row in window");
  endtask

  task automatic step(input bit t, input bit e, input int s);
    int f, l;
    @(negedge clk);
    tick = t; en = e; sel = 3'(s);
    @(posedge clk);
    m_req = 0;
    m_tag = "R6";
    if (t && !e) m_tag = "R9";
    if (t && e) begin
      window(s, f, l);
      if (s != m_code) begin
        m_code = s; m_row = f; m_tag = "R8";
      end
      m_first = f; m_last = l; m_none = (s == 4);
      if (s == 4) m_tag = "R5";
      else begin
        m_req = 1; m_addr = m_row;
        if (m_row == l) begin m_row = f; m_tag = "R7"; end
        else m_row = m_row + 1;
      end
    end
    #1 compare();
  endtask

  task automatic run(input int n, input int s, input bit every_other);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b1, s);
      if (every_other) step(1'b0, 1'b1, s);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    #1;
    // R1 reset state
    chk(refresh_req == 1'b0, "R1", int'(refresh_req), 0, "reset req");
    chk(row_addr == 14'd0, "R1", int'(row_addr), 0, "reset row");
    chk(win_first == 14'd0, "R1", int'(win_first), 0, "reset first");
    chk(win_last == 14'd16383, "R1", int'(win_last), 16383, "reset last");
    chk(no_refresh == 1'b0, "R1", int'(no_refresh), 0, "reset none");

    run(20, 0, 1);                         // R2 full window, spaced ticks
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 3); // R9 ticks with en low
    run(5, 0, 0);                          // R9 resumes sequence
    run(30, 1, 0);                         // R3 lower half
    run(30, 2, 1);                         // R3 lower quarter
    run(2060, 3, 0);                       // R3, R7 lower eighth wrap
    run(2060, 7, 0);                       // R4, R7 upper eighth wrap
    run(4100, 6, 0);                       // R4, R7 upper quarter wrap
    run(40, 5, 1);                         // R4 upper half
    run(12, 4, 0);                         // R5 none selected
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 5); // R9 code not applied
    run(12, 5, 0);                         // R8 leave none
    run(10, 4, 1);                         // R5 again
    run(10, 7, 0);                         // R8 reload from rest
    for (int i = 0; i < 400; i++)          // mixed stream
      step(1'($urandom_range(0, 1)), 1'($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      fails++;
      $display("FAIL R6 watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule